// File: doc/BRIEF.md
# Auto-Stepping Memory Address Pointer

This block holds the pointer that names the memory word used by instructions that address memory through the pointer or through an absolute address. It keeps a foreground and a background copy of the pointer. A register-set select input chooses which copy is active. Only the active copy is loaded or stepped, and only the active copy appears on the address output. The output always shows the address that the next pointer-referencing access will use.

The active copy can be loaded directly with a value. It can also be loaded indirectly from the absolute address field of an instruction. After each qualifying access, the copy moves up by one, moves down by one, or stays where it is, as chosen by a two-bit step mode. The copy wraps modulo 2^ADDR_W.

Data cycles that go to a persistent memory source or destination advance a two-bit segment counter. Only the cycle that reaches the end-limit segment steps the pointer. The memory array and the instruction decoder are outside this block.

Top module: `mem_addr_ptr`

## Requirements
- R1: After reset, both pointer copies are 0 and the segment counter is 0.
- R2: With `load_i` high, the active copy takes `load_addr_i` on the next clock and the segment counter returns to 0. No stepping is applied to the loaded value.
- R3: With `abs_i` high and `load_i` low, the active copy becomes `abs_addr_i` stepped once by the current step mode, and the segment counter returns to 0.
- R4: With `ptr_acc_i` high and no load, the active copy steps after the access according to `step_mode_i`: 2'b01 adds one, 2'b10 subtracts one, and 2'b00 or 2'b11 leaves it unchanged.
- R5: Stepping wraps modulo 2^ADDR_W: decrement from 0 gives 2^ADDR_W-1, and increment from 2^ADDR_W-1 gives 0.
- R6: A data cycle (`data_acc_i`, with no instruction input high) advances the segment counter from 0 toward `seg_limit_i`. The cycle that finds the counter equal to `seg_limit_i` returns it to 0 and steps the active copy. Every other data cycle leaves the pointer unchanged.
- R7: `addr_o` shows the copy chosen by `bank_sel_i` (0 selects foreground, 1 selects background). The copy that is not selected keeps its value through every operation.
- R8: When several request inputs are high together, only one request is served, in the priority order `load_i`, `abs_i`, `ptr_acc_i`, `data_acc_i`. The other requests have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bank_sel_i | input | 1 | Active copy: 0 selects foreground, 1 selects background |
| step_mode_i | input | 2 | Step mode: 01 increment, 10 decrement, 00 or 11 hold |
| seg_limit_i | input | SEG_W | End-limit segment index |
| load_i | input | 1 | Direct load of the active copy |
| load_addr_i | input | ADDR_W | Value for a direct load |
| abs_i | input | 1 | Instruction that uses an absolute address |
| abs_addr_i | input | ADDR_W | Absolute address field |
| ptr_acc_i | input | 1 | Instruction that accesses memory at the pointer |
| data_acc_i | input | 1 | Data cycle to a persistent memory source or destination |
| addr_o | output | ADDR_W | Active pointer value, which is the address for the next access |
| seg_o | output | SEG_W | Current segment counter |

## Verification
The hardest case to reach is a data-cycle step at the end limit that also crosses the address boundary. Reaching it needs the pointer to sit at an edge, and then a run of data cycles that exactly matches the programmed limit. The stimulus table reaches it in stages. It first builds segment runs with limits of 2, 0 and 3. It then combines a load to the top address with a data request in the same cycle, which proves that the load takes priority and clears the counter. A plain pointer access then wraps the pointer to zero. Background-copy operations are interleaved with these steps, and the foreground value is checked again afterwards, to show that the inactive copy was untouched.

// File: rtl/mem_ptr_pkg.sv
package mem_ptr_pkg;
  typedef enum logic [1:0] {
    STEP_HOLD  = 2'b00,
    STEP_UP    = 2'b01,
    STEP_DOWN  = 2'b10,
    STEP_HOLD3 = 2'b11
  } step_e;
endpackage

// File: rtl/ptr_step.sv
module ptr_step
  import mem_ptr_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        mode_i,
  output logic [ADDR_W-1:0] addr_o
);
  always_comb begin
    unique case (step_e'(mode_i))
      STEP_UP:   addr_o = addr_i + ADDR_W'(1);
      STEP_DOWN: addr_o = addr_i - ADDR_W'(1);
      default:   addr_o = addr_i;
    endcase
  end
endmodule

// File: rtl/seg_counter.sv
module seg_counter #(
  parameter int SEG_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             adv_i,
  input  logic [SEG_W-1:0] limit_i,
  output logic [SEG_W-1:0] seg_o,
  output logic             wrap_o
);
  logic [SEG_W-1:0] seg_q;

  assign wrap_o = adv_i && (seg_q == limit_i);
  assign seg_o  = seg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     seg_q <= '0;
    else if (clr_i)  seg_q <= '0;
    else if (wrap_o) seg_q <= '0;
    else if (adv_i)  seg_q <= seg_q + SEG_W'(1);
  end
endmodule

// File: rtl/ptr_bank.sv
module ptr_bank #(
  parameter int ADDR_W = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] d_i,
  output logic [ADDR_W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (we_i) q_o <= d_i;
  end
endmodule

// File: rtl/mem_addr_ptr.sv
module mem_addr_ptr #(
  parameter int ADDR_W = 11,
  parameter int SEG_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bank_sel_i,
  input  logic [1:0]        step_mode_i,
  input  logic [SEG_W-1:0]  seg_limit_i,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_addr_i,
  input  logic              abs_i,
  input  logic [ADDR_W-1:0] abs_addr_i,
  input  logic              ptr_acc_i,
  input  logic              data_acc_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [SEG_W-1:0]  seg_o
);
  localparam int NUM_BANKS = 2;

  logic [ADDR_W-1:0] bank_q [NUM_BANKS];
  logic [ADDR_W-1:0] step_base, stepped, wr_data;
  logic              wr_en, seg_clr, seg_adv, seg_wrap;

  assign addr_o = bank_q[bank_sel_i];

  // abs instruction steps from its own address field
  assign step_base = (abs_i && !load_i) ? abs_addr_i : addr_o;
  assign seg_clr   = load_i || abs_i;
  assign seg_adv   = data_acc_i && !load_i && !abs_i && !ptr_acc_i;

  ptr_step #(.ADDR_W(ADDR_W)) u_step (
    .addr_i (step_base),
    .mode_i (step_mode_i),
    .addr_o (stepped)
  );

  seg_counter #(.SEG_W(SEG_W)) u_seg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (seg_clr),
    .adv_i   (seg_adv),
    .limit_i (seg_limit_i),
    .seg_o   (seg_o),
    .wrap_o  (seg_wrap)
  );

  always_comb begin
    wr_en   = load_i || abs_i || ptr_acc_i || seg_wrap;
    wr_data = load_i ? load_addr_i : stepped;
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    ptr_bank #(.ADDR_W(ADDR_W)) u_bank (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .we_i   (wr_en && (bank_sel_i == b[0])),
      .d_i    (wr_data),
      .q_o    (bank_q[b])
    );
  end

  assert_inactive_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bank_sel_i |=> bank_q[1] == $past(bank_q[1]));

  assert_load_value_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !bank_sel_i) |=> (bank_q[0] == $past(load_addr_i)) && (seg_o == '0));

  assert_hold_mode_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ptr_acc_i && !load_i && !abs_i && !bank_sel_i &&
     (step_mode_i == 2'b00 || step_mode_i == 2'b11)) |=> $stable(bank_q[0]));

  assert_inc_wrap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ptr_acc_i && !load_i && !abs_i && !bank_sel_i && step_mode_i == 2'b01)
    |=> bank_q[0] == ADDR_W'($past(bank_q[0]) + ADDR_W'(1)));

  assert_seg_return_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_acc_i && !load_i && !abs_i && !ptr_acc_i && seg_o == seg_limit_i)
    |=> seg_o == '0);

  assert_prio_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ptr_acc_i && data_acc_i && !load_i && !abs_i) |=> $stable(seg_o));
endmodule

// File: tb/mem_addr_ptr_tb.sv
`timescale 1ns/1ps
module mem_addr_ptr_tb;
  localparam int ADDR_W = 11;
  localparam int SEG_W  = 2;
  localparam int NVEC   = 19;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bank_sel = 1'b0;
  logic [1:0] mode = 2'b00;
  logic [SEG_W-1:0] lim = '0;
  logic ld = 1'b0, ab = 1'b0, pa = 1'b0, da = 1'b0;
  logic [ADDR_W-1:0] ld_addr = '0, ab_addr = '0;
  logic [ADDR_W-1:0] addr;
  logic [SEG_W-1:0] seg;

  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  mem_addr_ptr #(.ADDR_W(ADDR_W), .SEG_W(SEG_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .bank_sel_i(bank_sel), .step_mode_i(mode),
    .seg_limit_i(lim), .load_i(ld), .load_addr_i(ld_addr), .abs_i(ab),
    .abs_addr_i(ab_addr), .ptr_acc_i(pa), .data_acc_i(da),
    .addr_o(addr), .seg_o(seg)
  );

  // {sel, mode, lim, ld, ab, pa, da, addr_in, exp_addr, exp_seg}
  localparam logic [32:0] VEC [NVEC] = '{
    {1'b0, 2'b00, 2'd0, 4'b1000, 11'h100, 11'h100, 2'd0}, // R2 load
    {1'b0, 2'b01, 2'd0, 4'b0010, 11'h000, 11'h101, 2'd0}, // R4 inc
    {1'b0, 2'b01, 2'd0, 4'b0010, 11'h000, 11'h102, 2'd0}, // R4 inc
    {1'b0, 2'b10, 2'd0, 4'b0010, 11'h000, 11'h101, 2'd0}, // R4 dec
    {1'b0, 2'b11, 2'd0, 4'b0010, 11'h000, 11'h101, 2'd0}, // R4 hold 11
    {1'b0, 2'b00, 2'd0, 4'b0010, 11'h000, 11'h101, 2'd0}, // R4 hold 00
    {1'b1, 2'b01, 2'd0, 4'b0010, 11'h000, 11'h001, 2'd0}, // R7 bg inc
    {1'b1, 2'b10, 2'd0, 4'b0010, 11'h000, 11'h000, 2'd0}, // R7 bg dec
    {1'b1, 2'b10, 2'd0, 4'b0010, 11'h000, 11'h7FF, 2'd0}, // R5 wrap down
    {1'b0, 2'b00, 2'd0, 4'b0000, 11'h000, 11'h101, 2'd0}, // R7 fg untouched
    {1'b0, 2'b01, 2'd0, 4'b0100, 11'h200, 11'h201, 2'd0}, // R3 abs
    {1'b0, 2'b01, 2'd2, 4'b0001, 11'h000, 11'h201, 2'd1}, // R6 seg 1
    {1'b0, 2'b01, 2'd2, 4'b0001, 11'h000, 11'h201, 2'd2}, // R6 seg 2
    {1'b0, 2'b01, 2'd2, 4'b0001, 11'h000, 11'h202, 2'd0}, // R6 limit step
    {1'b0, 2'b01, 2'd0, 4'b0001, 11'h000, 11'h203, 2'd0}, // R6 limit 0
    {1'b0, 2'b01, 2'd3, 4'b0001, 11'h000, 11'h203, 2'd1}, // R6 seg 1
    {1'b0, 2'b01, 2'd3, 4'b1001, 11'h7FF, 11'h7FF, 2'd0}, // R8 load beats data
    {1'b0, 2'b01, 2'd0, 4'b0010, 11'h000, 11'h000, 2'd0}, // R5 wrap up
    {1'b1, 2'b01, 2'd0, 4'b0110, 11'h7FF, 11'h000, 2'd0}  // R8 abs over ptr, R5
  };

  task automatic check_val(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle();
    ld = 0; ab = 0; pa = 0; da = 0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_val("R1 fg", int'(addr), 0);
    check_val("R1 seg", int'(seg), 0);
    bank_sel = 1'b1;
    #1 check_val("R1 bg", int'(addr), 0);

    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      bank_sel = VEC[i][32];
      mode     = VEC[i][31:30];
      lim      = VEC[i][29:28];
      {ld, ab, pa, da} = VEC[i][27:24];
      ld_addr  = VEC[i][23:13];
      ab_addr  = VEC[i][23:13];
      @(posedge clk);
      @(negedge clk);
      idle();
      check_val($sformatf("vec%0d addr R2-R8 table", i), int'(addr), int'(VEC[i][12:2]));
      check_val($sformatf("vec%0d seg R6", i), int'(seg), int'(VEC[i][1:0]));
    end

    // R1: reset mid-run clears both copies and the counter
    bank_sel = 1'b0; mode = 2'b01; lim = 2'd3; da = 1'b1;
    @(negedge clk);
    idle();
    rst_n = 1'b0;
    #1;
    check_val("R1 fg after reset", int'(addr), 0);
    check_val("R1 seg after reset", int'(seg), 0);
    bank_sel = 1'b1;
    #1 check_val("R1 bg after reset", int'(addr), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R6: data cycles with limit 3 step on the fourth cycle only
    bank_sel = 1'b1; mode = 2'b10; lim = 2'd3;
    for (int k = 0; k < 4; k++) begin
      da = 1'b1;
      @(posedge clk);
      @(negedge clk);
      da = 1'b0;
      check_val("R6 limit3 addr", int'(addr), (k == 3) ? 11'h7FF : 0);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule